// File: doc/BRIEF.md
# Audio Stream Descriptor-List DMA Sequencer

This block moves the sample bytes of one audio stream between system memory and a local byte FIFO. Software builds a ring of 16-byte buffer descriptors in memory, programs the list base, the last-valid index, the cyclic buffer length, the FIFO size and the watermark, then sets the run bit. The sequencer fetches each descriptor and copies its buffer one byte per memory beat, in bursts no longer than the FIFO size plus one. It steps the descriptor index and wraps it after the last-valid entry. A parameter picks the direction: an output stream reads memory and pushes into the FIFO, an input stream pops the FIFO and writes memory.

Every finished burst adds its bytes to a held count. The held bytes join the link position only once they reach the watermark or exactly fill the cyclic buffer, so a small tail stays out of the reported position. The position wraps to zero at the cyclic buffer length. It can be written back to a position buffer in memory. A descriptor flagged for completion sets a sticky status bit that drives the interrupt line when its buffer ends.

Top module: `snd_dma_engine`

Register map (word address on `reg_addr`): 0 control (bit0 run, bit1 position writeback enable); 1 status (bit0 completion, write 1 to clear); 2 cyclic buffer length in bytes; 3 last-valid index; 4 watermark code; 5 FIFO size (bytes minus one); 6/7 descriptor list base low/high; 8/9 position buffer base low/high; 10 link position (read only). Reads are combinational from `reg_addr`.

State machine. The states are IDLE, DESC (four word reads of one descriptor), PLAN (size the next burst), MEMRD and FIFOOUT (one output byte), FIFOIN and MEMWR (one input byte), ACCOUNT (watermark and position update), POSWR (position writeback) and DESCEND (end of descriptor).

The transitions are:
- IDLE→DESC when run is set.
- DESC→PLAN after word 3.
- PLAN→IDLE when run is clear.
- PLAN→DESCEND when the descriptor has no bytes left.
- PLAN→ACCOUNT when the burst is empty.
- PLAN→MEMRD (output) or FIFOIN (input) otherwise.
- MEMRD→FIFOOUT on ack.
- FIFOIN→MEMWR on a valid byte.
- FIFOOUT or MEMWR→ACCOUNT when the burst is done or run is clear. Otherwise they go back to the first beat state.
- ACCOUNT→POSWR on a counted update with writeback enabled.
- ACCOUNT or POSWR→DESCEND when the offset reaches the length, else back to PLAN.
- DESCEND→DESC while run is set, else DESCEND→IDLE.

## Requirements
- R1: After reset the link position reads 0, status and `irq` are 0, the watermark code reads 4 and the FIFO size reads 191 for an output stream, and they read 2 and 119 for an input stream.
- R2: A watermark write of 2, 3 or 4 (meaning 8, 16 and 32 bytes) stores that value. Any other 32-bit write value stores 4.
- R3: Descriptor i is read as four 32-bit words at list base + 16*i + 0/4/8/12, where the list base is {high register, low register}. Word 0 is the buffer address low half and word 1 the high half. Word 2 is the byte length and bit 0 of word 3 is the completion flag. Read data carries the byte at `mem_addr` in bits 7:0 and the next bytes in the higher lanes.
- R4: An output stream delivers the bytes of descriptors 0..last-valid in order, one memory read per byte at buffer address + offset. After the last-valid index it wraps to descriptor 0.
- R5: Each burst moves min(FIFO size + 1, bytes left in the descriptor, cyclic length − position − held bytes) bytes.
- R6: Burst bytes are added to a held count. When held ≥ watermark bytes, or position + held equals the cyclic length, the held bytes are added to the position and the held count clears. Otherwise the position stays unchanged.
- R7: When the position reaches the cyclic buffer length it becomes 0.
- R8: When a nonzero-length descriptor with its completion flag set ends, the status bit and `irq` become 1 and stay 1 until status is written with bit0 = 1.
- R9: With writeback enabled, every counted position update is followed by a 32-bit write of the new (wrapped) position to position base + 8*STREAM_ID with all byte enables set.
- R10: The engine stays idle until run is set. When run is cleared, the byte in flight completes and the engine stops without fetching another descriptor or issuing any further memory request.
- R11: A zero-length descriptor is skipped with no data requests and never sets the completion status, even when flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Completion interrupt (status bit 0) |
| mem_req | output | 1 | Memory request, held until ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte enables relative to the aligned word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| fs_out_valid | output | 1 | Byte to FIFO valid (output stream) |
| fs_out_data | output | 8 | Byte to FIFO |
| fs_out_ready | input | 1 | FIFO accepts byte |
| fs_in_valid | input | 1 | Byte from FIFO valid (input stream) |
| fs_in_data | input | 8 | Byte from FIFO |
| fs_in_ready | output | 1 | Engine takes byte |

## Verification
A wrong descriptor index or offset shows up on the next memory read as a bad address, and on the FIFO side as a wrong byte in the sequence, within one beat. A wrong held count or burst size does not change the byte stream. It shows only in the link position read back and in the writeback word, after the next burst completes. The bench therefore stalls the FIFO at random byte counts and compares the position, the writeback value and the interrupt against a burst-level model. A lost run-stop shows as extra memory requests after the in-flight byte.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_DESC, S_PLAN, S_MEMRD, S_FIFOOUT,
        S_FIFOIN, S_MEMWR, S_ACCOUNT, S_POSWR, S_DESCEND
    } dma_state_t;

    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_STATUS = 4'd1;
    localparam logic [3:0] RA_CBL    = 4'd2;
    localparam logic [3:0] RA_LVI    = 4'd3;
    localparam logic [3:0] RA_WM     = 4'd4;
    localparam logic [3:0] RA_FSZ    = 4'd5;
    localparam logic [3:0] RA_BDL_LO = 4'd6;
    localparam logic [3:0] RA_BDL_HI = 4'd7;
    localparam logic [3:0] RA_POS_LO = 4'd8;
    localparam logic [3:0] RA_POS_HI = 4'd9;
    localparam logic [3:0] RA_LPIB   = 4'd10;

    function automatic logic [31:0] wm_bytes(input logic [2:0] code);
        unique case (code)
            3'd2:    wm_bytes = 32'd8;
            3'd3:    wm_bytes = 32'd16;
            default: wm_bytes = 32'd32;
        endcase
    endfunction
endpackage

// File: rtl/snd_dma_regs.sv
module snd_dma_regs #(
    parameter bit IS_OUT = 1'b1,
    parameter int AW     = 64,
    parameter int IDX_W  = 8,
    parameter int FSZ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             run,
    output logic             wb_en,
    output logic [31:0]      cbl,
    output logic [IDX_W-1:0] lvi,
    output logic [2:0]       wm_code,
    output logic [FSZ_W-1:0] fifo_sz,
    output logic [AW-1:0]    bdl_base,
    output logic [AW-1:0]    pos_base,
    input  logic [31:0]      lpib,
    input  logic             set_done,
    output logic             irq
);
    import snd_dma_pkg::*;

    localparam logic [2:0]       WM_RST  = IS_OUT ? 3'd4 : 3'd2;
    localparam logic [FSZ_W-1:0] FSZ_RST = IS_OUT ? FSZ_W'(191) : FSZ_W'(119);

    logic [31:0] bdl_lo, bdl_hi, pos_lo, pos_hi;
    logic        done_q;

    assign bdl_base = AW'({bdl_hi, bdl_lo});
    assign pos_base = AW'({pos_hi, pos_lo});
    assign irq      = done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; wb_en <= 1'b0; cbl <= '0; lvi <= '0;
            wm_code <= WM_RST; fifo_sz <= FSZ_RST; done_q <= 1'b0;
            bdl_lo <= '0; bdl_hi <= '0; pos_lo <= '0; pos_hi <= '0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    RA_CTRL:   begin run <= wdata[0]; wb_en <= wdata[1]; end
                    RA_CBL:    cbl <= wdata;
                    RA_LVI:    lvi <= wdata[IDX_W-1:0];
                    RA_WM:     wm_code <= (wdata == 32'd2 || wdata == 32'd3 || wdata == 32'd4)
                                          ? wdata[2:0] : 3'd4;
                    RA_FSZ:    fifo_sz <= wdata[FSZ_W-1:0];
                    RA_BDL_LO: bdl_lo <= wdata;
                    RA_BDL_HI: bdl_hi <= wdata;
                    RA_POS_LO: pos_lo <= wdata;
                    RA_POS_HI: pos_hi <= wdata;
                    default:   ;
                endcase
            end
            if (set_done)
                done_q <= 1'b1;
            else if (wr_en && addr == RA_STATUS && wdata[0])
                done_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL:   rdata = {30'd0, wb_en, run};
            RA_STATUS: rdata = {31'd0, done_q};
            RA_CBL:    rdata = cbl;
            RA_LVI:    rdata = 32'(lvi);
            RA_WM:     rdata = {29'd0, wm_code};
            RA_FSZ:    rdata = 32'(fifo_sz);
            RA_BDL_LO: rdata = bdl_lo;
            RA_BDL_HI: rdata = bdl_hi;
            RA_POS_LO: rdata = pos_lo;
            RA_POS_HI: rdata = pos_hi;
            RA_LPIB:   rdata = lpib;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/snd_dma_seq.sv
module snd_dma_seq #(
    parameter bit IS_OUT    = 1'b1,
    parameter int AW        = 64,
    parameter int IDX_W     = 8,
    parameter int FSZ_W     = 8,
    parameter int STREAM_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wb_en,
    input  logic [31:0]      cbl,
    input  logic [IDX_W-1:0] lvi,
    input  logic [2:0]       wm_code,
    input  logic [FSZ_W-1:0] fifo_sz,
    input  logic [AW-1:0]    bdl_base,
    input  logic [AW-1:0]    pos_base,
    output logic [31:0]      lpib,
    output logic             set_done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             fs_out_valid,
    output logic [7:0]       fs_out_data,
    input  logic             fs_out_ready,
    input  logic             fs_in_valid,
    input  logic [7:0]       fs_in_data,
    output logic             fs_in_ready
);
    import snd_dma_pkg::*;

    localparam dma_state_t FIRST_BEAT = IS_OUT ? S_MEMRD : S_FIFOIN;
    localparam logic [AW-1:0] POS_OFS = AW'(STREAM_ID * 8);

    dma_state_t state, state_nx;

    logic [1:0]       beat;
    logic [IDX_W-1:0] idx;
    logic [31:0]      off, len, burst_n, done, held;
    logic [AW-1:0]    buf_addr;
    logic             ioc;
    logic [7:0]       byte_q;

    logic [31:0] rem, room, cap, plan_n, held_sum;
    logic        flush, byte_hs, burst_end, desc_end;

    always_comb begin
        rem  = len - off;
        room = cbl - lpib - held;
        cap  = 32'(fifo_sz) + 32'd1;
        plan_n = (rem < cap) ? rem : cap;
        if (room < plan_n) plan_n = room;
        held_sum  = held + done;
        flush     = (held_sum >= wm_bytes(wm_code)) || (lpib + held_sum == cbl);
        byte_hs   = (state == S_FIFOOUT && fs_out_ready) || (state == S_MEMWR && mem_ack);
        burst_end = (done + 32'd1 == burst_n) || !run;
        desc_end  = (off == len);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (run) state_nx = S_DESC;
            S_DESC:    if (mem_ack && beat == 2'd3) state_nx = S_PLAN;
            S_PLAN: begin
                if (!run)               state_nx = S_IDLE;
                else if (rem == 32'd0)  state_nx = S_DESCEND;
                else if (plan_n == 0)   state_nx = S_ACCOUNT;
                else                    state_nx = FIRST_BEAT;
            end
            S_MEMRD:   if (mem_ack) state_nx = S_FIFOOUT;
            S_FIFOIN:  if (fs_in_valid) state_nx = S_MEMWR;
            S_FIFOOUT, S_MEMWR:
                if (byte_hs) state_nx = burst_end ? S_ACCOUNT : FIRST_BEAT;
            S_ACCOUNT: begin
                if (flush && wb_en) state_nx = S_POSWR;
                else                state_nx = desc_end ? S_DESCEND : S_PLAN;
            end
            S_POSWR:   if (mem_ack) state_nx = desc_end ? S_DESCEND : S_PLAN;
            S_DESCEND: state_nx = run ? S_DESC : S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; mem_be = 4'hF;
        mem_addr = '0; mem_wdata = '0;
        fs_out_valid = 1'b0; fs_in_ready = 1'b0;
        set_done = 1'b0;
        unique case (state)
            S_DESC: begin
                mem_req  = 1'b1;
                mem_addr = bdl_base + AW'({idx, 4'b0000}) + AW'({beat, 2'b00});
            end
            S_MEMRD: begin
                mem_req  = 1'b1;
                mem_addr = buf_addr + AW'(off);
            end
            S_MEMWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr + AW'(off);
                mem_be    = 4'b0001 << mem_addr[1:0];
                mem_wdata = {4{byte_q}};
            end
            S_POSWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pos_base + POS_OFS;
                mem_wdata = lpib;
            end
            S_FIFOOUT: fs_out_valid = 1'b1;
            S_FIFOIN:  fs_in_ready  = 1'b1;
            S_DESCEND: set_done = ioc && (len != 32'd0);
            default: ;
        endcase
    end
    assign fs_out_data = byte_q;

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0; idx <= '0; off <= '0; len <= '0; burst_n <= '0;
            done <= '0; held <= '0; lpib <= '0; buf_addr <= '0;
            ioc <= 1'b0; byte_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: beat <= '0;
                S_DESC: if (mem_ack) begin
                    beat <= beat + 2'd1;
                    unique case (beat)
                        2'd0: buf_addr[31:0] <= mem_rdata;
                        2'd1: buf_addr <= {AW'(mem_rdata) << 32} | AW'(buf_addr[31:0]);
                        2'd2: len <= mem_rdata;
                        default: ioc <= mem_rdata[0];
                    endcase
                end
                S_PLAN: begin
                    burst_n <= plan_n;
                    done    <= '0;
                end
                S_MEMRD:  if (mem_ack) byte_q <= mem_rdata[7:0];
                S_FIFOIN: if (fs_in_valid) byte_q <= fs_in_data;
                S_FIFOOUT, S_MEMWR: if (byte_hs) begin
                    off  <= off + 32'd1;
                    done <= done + 32'd1;
                end
                S_ACCOUNT: begin
                    if (flush) begin
                        lpib <= (lpib + held_sum == cbl) ? 32'd0 : lpib + held_sum;
                        held <= '0;
                    end else begin
                        held <= held_sum;
                    end
                    done <= '0;
                end
                S_DESCEND: begin
                    idx  <= (idx == lvi) ? '0 : idx + 1'b1;
                    off  <= '0;
                    beat <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/snd_dma_engine.sv
module snd_dma_engine #(
    parameter bit IS_OUT    = 1'b1,
    parameter int AW        = 64,
    parameter int IDX_W     = 8,
    parameter int FSZ_W     = 8,
    parameter int STREAM_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          fs_out_valid,
    output logic [7:0]    fs_out_data,
    input  logic          fs_out_ready,
    input  logic          fs_in_valid,
    input  logic [7:0]    fs_in_data,
    output logic          fs_in_ready
);
    logic             run, wb_en, set_done;
    logic [31:0]      cbl, lpib;
    logic [IDX_W-1:0] lvi;
    logic [2:0]       wm_code;
    logic [FSZ_W-1:0] fifo_sz;
    logic [AW-1:0]    bdl_base, pos_base;

    snd_dma_regs #(.IS_OUT(IS_OUT), .AW(AW), .IDX_W(IDX_W), .FSZ_W(FSZ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .run(run), .wb_en(wb_en),
        .cbl(cbl), .lvi(lvi), .wm_code(wm_code), .fifo_sz(fifo_sz),
        .bdl_base(bdl_base), .pos_base(pos_base), .lpib(lpib),
        .set_done(set_done), .irq(irq)
    );

    snd_dma_seq #(.IS_OUT(IS_OUT), .AW(AW), .IDX_W(IDX_W), .FSZ_W(FSZ_W),
                  .STREAM_ID(STREAM_ID)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .wb_en(wb_en), .cbl(cbl),
        .lvi(lvi), .wm_code(wm_code), .fifo_sz(fifo_sz),
        .bdl_base(bdl_base), .pos_base(pos_base), .lpib(lpib),
        .set_done(set_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fs_out_valid(fs_out_valid), .fs_out_data(fs_out_data),
        .fs_out_ready(fs_out_ready), .fs_in_valid(fs_in_valid),
        .fs_in_data(fs_in_data), .fs_in_ready(fs_in_ready)
    );
endmodule

// File: rtl/snd_dma_checker.sv
module snd_dma_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          fs_out_valid,
    input logic          fs_out_ready,
    input logic [7:0]    fs_out_data,
    input logic          irq,
    input logic          reg_wr_en,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   lpib,
    input logic [31:0]   cbl,
    input logic [2:0]    wm_code
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

    AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out_valid && !fs_out_ready |=> fs_out_valid && $stable(fs_out_data)); // R4

    AST_WM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wm_code >= 3'd2 && wm_code <= 3'd4); // R2

    AST_WM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == 4'd4 && reg_wdata >= 32'd2 && reg_wdata <= 32'd4
        |=> wm_code == $past(reg_wdata[2:0])); // R2

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(reg_wr_en && reg_addr == 4'd1 && reg_wdata[0]) |=> irq); // R8

    AST_LPIB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cbl) && lpib != $past(lpib) |-> lpib < cbl); // R7
endmodule

bind snd_dma_engine snd_dma_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .fs_out_valid(fs_out_valid),
    .fs_out_ready(fs_out_ready), .fs_out_data(fs_out_data), .irq(irq),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .lpib(lpib), .cbl(cbl), .wm_code(wm_code)
);

// File: tb/snd_dma_engine_bench.sv
module snd_dma_engine_bench;
    localparam int SID = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we, mem_ack, fs_out_valid, fs_out_ready, fs_in_ready;
    logic [63:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0]  fs_out_data;

    logic [31:0] in_rdata;
    logic        in_irq, in_req, in_we, in_ov, in_ir;
    logic [63:0] in_maddr;
    logic [3:0]  in_be;
    logic [31:0] in_wd;
    logic [7:0]  in_od;
    logic [3:0]  in_addr = '0;

    always #5 clk = ~clk;

    snd_dma_engine #(.STREAM_ID(SID)) u_snd_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fs_out_valid(fs_out_valid), .fs_out_data(fs_out_data),
        .fs_out_ready(fs_out_ready), .fs_in_valid(1'b0), .fs_in_data(8'd0),
        .fs_in_ready(fs_in_ready)
    );

    snd_dma_engine #(.IS_OUT(1'b0)) u_in (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(1'b0), .reg_addr(in_addr),
        .reg_wdata(32'd0), .reg_rdata(in_rdata), .irq(in_irq),
        .mem_req(in_req), .mem_we(in_we), .mem_addr(in_maddr), .mem_be(in_be),
        .mem_wdata(in_wd), .mem_ack(1'b0), .mem_rdata(32'd0),
        .fs_out_valid(in_ov), .fs_out_data(in_od), .fs_out_ready(1'b0),
        .fs_in_valid(1'b0), .fs_in_data(8'd0), .fs_in_ready(in_ir)
    );

    int checks = 0, errors = 0;
    logic [7:0] mem [0:4095];

    // memory responder
    int          req_cnt = 0, hi_err = 0, wb_cnt = 0;
    logic [31:0] wb_last = 32'hEEEEEEEE;
    logic [31:0] exp_hi = '0;
    logic        mon_clr = 1'b0;
    always @(posedge clk) begin
        if (mon_clr) begin
            req_cnt <= 0; hi_err <= 0; wb_cnt <= 0; wb_last <= 32'hEEEEEEEE;
        end
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack && ($urandom % 3 != 0)) begin
            logic [11:0] a;
            a = mem_addr[11:0];
            mem_ack   <= 1'b1;
            mem_rdata <= {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
            req_cnt   <= req_cnt + 1;
            if (mem_addr[63:32] != exp_hi) hi_err <= hi_err + 1;
            if (mem_we && a == 12'h800 + 12'(8 * SID) && mem_be == 4'hF) begin
                wb_last <= mem_wdata; wb_cnt <= wb_cnt + 1;
            end
        end else mem_ack <= 1'b0;
    end

    // FIFO sink
    logic [7:0] cap [0:1023];
    int  ncap = 0, sink_lim = 0;
    logic sink_clr = 1'b0;
    always @(posedge clk) begin
        int nx;
        nx = ncap;
        if (sink_clr) begin
            nx = 0; ncap <= 0;
        end else if (fs_out_valid && fs_out_ready) begin
            if (ncap < 1024) cap[ncap] <= fs_out_data;
            nx = ncap + 1; ncap <= nx;
        end
        fs_out_ready <= rst_n && (nx < sink_lim) && ($urandom % 4 != 0);
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    // scenario configuration
    int lens [4];
    bit iocs [4];
    int lvi, cbl, fsz, wmc, kb;
    bit wb;
    int exp_lpib, exp_irq;
    logic [31:0] exp_wb;

    function automatic int wmb(input int c);
        return (c == 2) ? 8 : (c == 3) ? 16 : 32;
    endfunction

    function automatic logic [7:0] byte_at(input int j);
        int tot = 0, r;
        for (int i = 0; i <= lvi; i++) tot += lens[i];
        r = j % tot;
        for (int i = 0; i <= lvi; i++) begin
            if (r < lens[i]) return mem[12'h400 + 12'(i * 128) + 12'(r)];
            r -= lens[i];
        end
        return 8'h00;
    endfunction

    // burst-level model of R4..R9, R11
    task automatic model();
        int idx = 0, off = 0, held = 0, lp = 0, moved = 0, n, rem;
        exp_irq = 0; exp_wb = 32'hEEEEEEEE;
        for (int step = 0; step < 5000; step++) begin
            rem = lens[idx] - off;
            if (rem == 0) begin
                if (lens[idx] != 0 && iocs[idx]) exp_irq = 1;
                idx = (idx == lvi) ? 0 : idx + 1; off = 0;
                continue;
            end
            n = fsz + 1;
            if (rem < n) n = rem;
            if (cbl - lp - held < n) n = cbl - lp - held;
            if (moved + n > kb) break;
            moved += n; off += n; held += n;
            if (held >= wmb(wmc) || lp + held == cbl) begin
                lp = (lp + held == cbl) ? 0 : lp + held;
                held = 0;
                if (wb) exp_wb = lp;
            end
        end
        exp_lpib = lp;
    endtask

    task automatic program_and_run(input logic [31:0] hi);
        for (int i = 0; i < 4; i++) begin
            logic [11:0] d;
            logic [31:0] w [4];
            d = 12'h100 + 12'(i * 16);
            w[0] = 32'h400 + 32'(i * 128); w[1] = hi; w[2] = lens[i]; w[3] = {31'd0, iocs[i]};
            for (int k = 0; k < 4; k++)
                for (int b = 0; b < 4; b++) mem[d + 12'(4 * k + b)] = w[k][8*b +: 8];
            for (int b = 0; b < 128; b++) mem[12'h400 + 12'(i * 128 + b)] = 8'($urandom);
        end
        exp_hi = hi;
        rst_n = 1'b0; sink_lim = 0; sink_clr = 1'b1; mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; sink_clr = 1'b0; mon_clr = 1'b0;
        wr(4'd2, cbl); wr(4'd3, lvi); wr(4'd4, wmc); wr(4'd5, fsz);
        wr(4'd6, 32'h100); wr(4'd7, hi); wr(4'd8, 32'h800); wr(4'd9, hi);
        sink_lim = kb;
        wr(4'd0, {30'd0, wb, 1'b1});
        while (ncap < kb) @(negedge clk);
        repeat (400) @(negedge clk);
    endtask

    task automatic verify(input string tag);
        logic [31:0] v;
        int bad = 0;
        model();
        for (int j = 0; j < kb; j++) if (cap[j] != byte_at(j)) bad++;
        check("R4", {tag, " byte mismatches"}, bad, 0);
        check("R3", {tag, " address high half errors"}, hi_err, 0);
        rd(4'd10, v);
        check("R5 R6 R7", {tag, " link position"}, v, exp_lpib);
        check("R8 R11", {tag, " irq"}, irq, exp_irq);
        check("R9", {tag, " writeback word"}, wb_last, exp_wb);
    endtask

    initial begin
        logic [31:0] v;
        int sum, rq, nc;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd10, v); check("R1", "reset link position", v, 0);
        rd(4'd1, v);  check("R1", "reset status", v, 0);
        check("R1", "reset irq", irq, 0);
        rd(4'd4, v);  check("R1", "out watermark code", v, 4);
        rd(4'd5, v);  check("R1", "out fifo size", v, 191);
        in_addr = 4'd4; #1 check("R1", "in watermark code", in_rdata, 2);
        in_addr = 4'd5; #1 check("R1", "in fifo size", in_rdata, 119);
        repeat (20) @(negedge clk);
        check("R10", "no request while idle", req_cnt, 0);

        // R2 watermark coercion
        wr(4'd4, 3); rd(4'd4, v); check("R2", "wm write 3", v, 3);
        wr(4'd4, 7); rd(4'd4, v); check("R2", "wm write 7", v, 4);
        wr(4'd4, 2); rd(4'd4, v); check("R2", "wm write 2", v, 2);
        wr(4'd4, 0); rd(4'd4, v); check("R2", "wm write 0", v, 4);
        wr(4'd4, 32'h10003); rd(4'd4, v); check("R2", "wm write 0x10003", v, 4);

        // directed: flagged zero-length descriptor never completes (R11)
        lens = '{40, 0, 25, 7}; iocs = '{0, 1, 0, 0};
        lvi = 3; cbl = 72; fsz = 15; wmc = 3; wb = 1; kb = 45;
        program_and_run(32'd0); verify("zero-len ioc");

        // directed: completion on descriptor 2, then write-1-to-clear (R8)
        iocs = '{0, 0, 1, 0}; kb = 70;
        program_and_run(32'd1); verify("ioc desc2");
        wr(4'd1, 32'd1); rd(4'd1, v);
        check("R8", "status after clear", v, 0);
        check("R8", "irq after clear", irq, 0);

        // directed: small tail under watermark at cyclic length (R6 R7)
        lens = '{30, 5, 0, 0}; iocs = '{1, 0, 0, 0};
        lvi = 1; cbl = 35; fsz = 7; wmc = 4; wb = 1; kb = 100;
        program_and_run(32'd0); verify("tail");

        // random scenarios
        for (int it = 0; it < 7; it++) begin
            for (int i = 0; i < 4; i++) begin lens[i] = $urandom % 41; iocs[i] = $urandom % 2; end
            lvi = $urandom % 4;
            sum = 0;
            for (int i = 0; i <= lvi; i++) sum += lens[i];
            if (sum == 0) begin lens[0] = 9; sum = 9; end
            cbl = 1 + $urandom % (sum + 30);
            fsz = 2 + $urandom % 30;
            wmc = 2 + $urandom % 3;
            wb  = $urandom % 2;
            kb  = 20 + $urandom % 150;
            program_and_run(32'($urandom % 3));
            verify($sformatf("rand%0d", it));
        end

        // R10: clear run while a byte waits at the FIFO
        lens = '{40, 0, 25, 7}; iocs = '{0, 0, 1, 0};
        lvi = 3; cbl = 72; fsz = 15; wmc = 3; wb = 0; kb = 30;
        program_and_run(32'd0);
        wr(4'd0, 32'd0);
        rq = req_cnt; nc = ncap;
        sink_lim = kb + 50;
        repeat (400) @(negedge clk);
        check("R10", "bytes after stop", ncap, nc + 1);
        check("R10", "requests after stop", req_cnt, rq);
        check("R10", "last byte value", cap[kb], byte_at(kb));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule